// File: doc/BRIEF.md
# Quadrant-one compressed instruction decoder

This block decodes one 16-bit compressed RISC-V instruction word whose two low bits select the quadrant-one group. It is purely combinational. It classifies the word into an operation, selects the register index the operation names, and reassembles the scattered immediate bits into a sign-extended immediate or control-transfer offset. It also flags encodings that are reserved for that operation and gives a reason code.

A mode input selects between the 32-bit and 64-bit base widths. Under RV32, funct3 = 001 is a linked jump, and under RV64 the same encoding is a word-sized add-immediate. A front end places this decoder between the fetch buffer and the register read stage. It reads the operation code, the register index and the immediate in the same cycle the word is presented.

Top module: `cq1_decoder`

## Requirements
- R1: `valid` is 1 exactly when insn[1:0] = 01. While `valid` is 0, `op` is 15, and `illegal`, `reason` and `is_call` are all 0.
- R2: funct3 (insn[15:13]) selects the operation code. 000 gives 0 (ADDI), 010 gives 3 (LI) and 100 gives 6 (ALU group). For these three, and for ADDIW, the immediate is {insn[12], insn[6:2]} sign-extended from that 6-bit value.
- R3: ADDI is illegal when exactly one of two conditions holds: the register field insn[11:7] is 0, or the immediate is 0. Reason 1 means the register is x0 and reason 2 means the immediate is zero. When both conditions hold, ADDI is legal.
- R4: ADDIW (code 1) and LI are illegal with reason 1 when insn[11:7] = 0.
- R5: funct3 = 011 with insn[11:7] = 2 gives code 4 (stack adjust). Its immediate places insn[12] in bit 9, insn[4:3] in bits 8:7, insn[5] in bit 6, insn[2] in bit 5 and insn[6] in bit 4, with bits 3:0 zero, and is sign-extended from bit 9. A zero immediate makes it illegal with reason 2.
- R6: funct3 = 011 with any other register field gives code 5 (LUI). Its immediate is the 6-bit value sign-extended and shifted left by 12. A register field of 0 or 2 gives reason 1, and this check takes priority. Otherwise a zero immediate gives reason 2.
- R7: Jump offsets are sign-extended from bit 11 and bit 0 is always 0. The bit placement is: bit 11 = insn[12], bit 10 = insn[8], bits 9:8 = insn[10:9], bit 7 = insn[6], bit 6 = insn[7], bit 5 = insn[2], bit 4 = insn[11], bits 3:1 = insn[5:3]. funct3 = 001 under RV32 gives code 2 (JAL) with `rd` = 1 and `is_call` = 1. funct3 = 101 gives code 7 (J) with `rd` = 0 and `is_call` = 0. Under RV64, funct3 = 001 gives ADDIW.
- R8: funct3 = 110 gives code 8 and funct3 = 111 gives code 9. The offset places insn[12] in bit 8, insn[6:5] in bits 7:6, insn[2] in bit 5, insn[11:10] in bits 4:3 and insn[4:3] in bits 2:1, with bit 0 zero, and is sign-extended from bit 8. `rd` is 8 + insn[9:7]. The ALU group takes its `rd` the same way.
- R9: For ADDI, ADDIW, LI, LUI and the stack adjust, `rd` equals insn[11:7]. `illegal` is 1 exactly when `reason` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 16 | Compressed instruction word |
| rv64 | input | 1 | 1 selects the 64-bit base width |
| valid | output | 1 | Word belongs to quadrant one |
| op | output | 4 | Operation code |
| rd | output | 5 | Register index named by the operation |
| imm | output | IMM_W (64) | Sign-extended immediate or offset |
| illegal | output | 1 | Reserved encoding for this operation |
| reason | output | 2 | 0 none, 1 register x0/x2, 2 zero immediate |
| is_call | output | 1 | Direct unconditional call (linked jump) |

## Verification
Every output is due in the same cycle as the word that produces it, because no register lies between `insn` and any output. Each task applies a word just after a rising clock edge and samples the outputs 2 ns later, well before the next edge. A check therefore never reads values left over from the previous stimulus. The bench also sweeps all 16384 quadrant-one encodings in both modes against a reference written in the bench, one word per cycle.

// File: rtl/cq1_pkg.sv
package cq1_pkg;

    localparam int INSN_W = 16;
    localparam int REG_W  = 5;

    typedef enum logic [3:0] {
        OP_ADDI     = 4'd0,
        OP_ADDIW    = 4'd1,
        OP_JAL      = 4'd2,
        OP_LI       = 4'd3,
        OP_ADDI16SP = 4'd4,
        OP_LUI      = 4'd5,
        OP_ALU      = 4'd6,
        OP_J        = 4'd7,
        OP_BEQZ     = 4'd8,
        OP_BNEZ     = 4'd9,
        OP_NONE     = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        FMT_SMALL,
        FMT_STACK,
        FMT_UPPER,
        FMT_JUMP,
        FMT_BRANCH
    } fmt_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_REG_X0   = 2'd1,
        RSN_IMM_ZERO = 2'd2
    } rsn_e;

endpackage

// File: rtl/cq1_classify.sv
module cq1_classify
    import cq1_pkg::*;
(
    input  logic [2:0]       funct3,
    input  logic [REG_W-1:0] reg_hi,
    input  logic             rv64,
    output op_e              op,
    output fmt_e             fmt,
    output logic [REG_W-1:0] rd,
    output logic             is_call
);

    localparam logic [REG_W-1:0] LINK_REG = REG_W'(1);
    localparam logic [REG_W-1:0] SP_REG   = REG_W'(2);

    logic [REG_W-1:0] short_reg;

    // Three-bit register fields name x8..x15.
    assign short_reg = {2'b01, reg_hi[2:0]};

    always_comb begin
        op      = OP_NONE;
        fmt     = FMT_SMALL;
        rd      = reg_hi;
        is_call = 1'b0;
        unique case (funct3)
            3'b000: begin
                op  = OP_ADDI;
                fmt = FMT_SMALL;
            end
            3'b001: begin
                if (rv64) begin
                    op  = OP_ADDIW;
                    fmt = FMT_SMALL;
                end else begin
                    op      = OP_JAL;
                    fmt     = FMT_JUMP;
                    rd      = LINK_REG;
                    is_call = 1'b1;
                end
            end
            3'b010: begin
                op  = OP_LI;
                fmt = FMT_SMALL;
            end
            3'b011: begin
                if (reg_hi == SP_REG) begin
                    op  = OP_ADDI16SP;
                    fmt = FMT_STACK;
                end else begin
                    op  = OP_LUI;
                    fmt = FMT_UPPER;
                end
            end
            3'b100: begin
                op  = OP_ALU;
                fmt = FMT_SMALL;
                rd  = short_reg;
            end
            3'b101: begin
                op  = OP_J;
                fmt = FMT_JUMP;
                rd  = '0;
            end
            3'b110: begin
                op  = OP_BEQZ;
                fmt = FMT_BRANCH;
                rd  = short_reg;
            end
            3'b111: begin
                op  = OP_BNEZ;
                fmt = FMT_BRANCH;
                rd  = short_reg;
            end
        endcase
    end

endmodule

// File: rtl/cq1_imm_build.sv
module cq1_imm_build
    import cq1_pkg::*;
#(
    parameter int IMM_W = 64
) (
    input  logic [12:2]      f,
    input  fmt_e             fmt,
    output logic [IMM_W-1:0] imm,
    output logic             imm_zero
);

    logic [IMM_W-1:0] small_imm;
    logic [IMM_W-1:0] stack_imm;
    logic [IMM_W-1:0] upper_imm;
    logic [IMM_W-1:0] jump_imm;
    logic [IMM_W-1:0] branch_imm;

    // Six-bit signed value from bit 12 and bits 6:2.
    assign small_imm  = {{(IMM_W-5){f[12]}}, f[6:2]};

    // Stack adjust: multiple of 16, sign at bit 9.
    assign stack_imm  = {{(IMM_W-9){f[12]}}, f[4:3], f[5], f[2], f[6], 4'b0000};

    // Upper immediate: six-bit signed value placed at bit 12.
    assign upper_imm  = {{(IMM_W-17){f[12]}}, f[6:2], 12'h000};

    // Jump offset: sign at bit 11, halfword aligned.
    assign jump_imm   = {{(IMM_W-11){f[12]}}, f[8], f[10:9], f[6], f[7],
                         f[2], f[11], f[5:3], 1'b0};

    // Branch offset: sign at bit 8, halfword aligned.
    assign branch_imm = {{(IMM_W-8){f[12]}}, f[6:5], f[2], f[11:10],
                         f[4:3], 1'b0};

    always_comb begin
        unique case (fmt)
            FMT_SMALL:  imm = small_imm;
            FMT_STACK:  imm = stack_imm;
            FMT_UPPER:  imm = upper_imm;
            FMT_JUMP:   imm = jump_imm;
            FMT_BRANCH: imm = branch_imm;
            default:    imm = '0;
        endcase
    end

    assign imm_zero = (imm == '0);

endmodule

// File: rtl/cq1_legality.sv
module cq1_legality
    import cq1_pkg::*;
(
    input  op_e              op,
    input  logic [REG_W-1:0] reg_field,
    input  logic             imm_zero,
    output logic             illegal,
    output rsn_e             reason
);

    logic reg_is_zero;
    logic reg_is_sp;

    assign reg_is_zero = (reg_field == '0);
    assign reg_is_sp   = (reg_field == REG_W'(2));

    always_comb begin
        reason = RSN_NONE;
        case (op)
            OP_ADDI: begin
                if (reg_is_zero && !imm_zero)
                    reason = RSN_REG_X0;
                else if (!reg_is_zero && imm_zero)
                    reason = RSN_IMM_ZERO;
            end
            OP_ADDIW, OP_LI: begin
                if (reg_is_zero)
                    reason = RSN_REG_X0;
            end
            OP_ADDI16SP: begin
                if (imm_zero)
                    reason = RSN_IMM_ZERO;
            end
            OP_LUI: begin
                if (reg_is_zero || reg_is_sp)
                    reason = RSN_REG_X0;
                else if (imm_zero)
                    reason = RSN_IMM_ZERO;
            end
            default: reason = RSN_NONE;
        endcase
    end

    assign illegal = (reason != RSN_NONE);

endmodule

// File: rtl/cq1_decoder.sv
module cq1_decoder
    import cq1_pkg::*;
#(
    parameter int IMM_W = 64
) (
    input  logic [15:0]      insn,
    input  logic             rv64,
    output logic             valid,
    output logic [3:0]       op,
    output logic [4:0]       rd,
    output logic [IMM_W-1:0] imm,
    output logic             illegal,
    output logic [1:0]       reason,
    output logic             is_call
);

    localparam logic [1:0] QUADRANT_ONE = 2'b01;

    op_e              cls_op;
    fmt_e             cls_fmt;
    logic [REG_W-1:0] cls_rd;
    logic             cls_call;
    logic             imm_is_zero;
    logic             rule_illegal;
    rsn_e             rule_reason;

    assign valid = (insn[1:0] == QUADRANT_ONE);

    cq1_classify u_classify (
        .funct3  (insn[15:13]),
        .reg_hi  (insn[11:7]),
        .rv64    (rv64),
        .op      (cls_op),
        .fmt     (cls_fmt),
        .rd      (cls_rd),
        .is_call (cls_call)
    );

    cq1_imm_build #(
        .IMM_W (IMM_W)
    ) u_imm (
        .f        (insn[12:2]),
        .fmt      (cls_fmt),
        .imm      (imm),
        .imm_zero (imm_is_zero)
    );

    cq1_legality u_legal (
        .op        (cls_op),
        .reg_field (insn[11:7]),
        .imm_zero  (imm_is_zero),
        .illegal   (rule_illegal),
        .reason    (rule_reason)
    );

    assign op      = valid ? cls_op : OP_NONE;
    assign rd      = cls_rd;
    assign illegal = valid & rule_illegal;
    assign reason  = valid ? rule_reason : RSN_NONE;
    assign is_call = valid & cls_call;

endmodule

// File: rtl/cq1_decoder_checker.sv
module cq1_decoder_checker
    import cq1_pkg::*;
#(
    parameter int IMM_W = 64
) (
    input logic [15:0]      insn,
    input logic             rv64,
    input logic             valid,
    input logic [3:0]       op,
    input logic [4:0]       rd,
    input logic [IMM_W-1:0] imm,
    input logic             illegal,
    input logic [1:0]       reason,
    input logic             is_call
);

    always_comb begin
        if (!$isunknown({insn, rv64})) begin
            a_r1_quiet_outside: assert (valid || (!illegal && reason == 2'd0 && !is_call && op == OP_NONE));
            a_r9_flag_has_reason: assert (illegal == (reason != 2'd0));
            a_r7_jump_aligned: assert (!(op == OP_JAL || op == OP_J) || (imm[0] == 1'b0 && rd[4:1] == 4'd0));
            a_r7_call_rv32_only: assert (!is_call || (!rv64 && rd == 5'd1 && op == OP_JAL));
            a_r6_upper_page: assert (op != OP_LUI || imm[11:0] == 12'h000);
            a_r5_stack_align: assert (op != OP_ADDI16SP || (imm[3:0] == 4'h0 && rd == 5'd2));
            a_r8_branch_span: assert (!(op == OP_BEQZ || op == OP_BNEZ) ||
                                      (rd[4:3] == 2'b01 && (imm[IMM_W-1:8] == '0 || &imm[IMM_W-1:8])));
        end
    end

endmodule

bind cq1_decoder cq1_decoder_checker #(.IMM_W(IMM_W)) u_chk (
    .insn    (insn),
    .rv64    (rv64),
    .valid   (valid),
    .op      (op),
    .rd      (rd),
    .imm     (imm),
    .illegal (illegal),
    .reason  (reason),
    .is_call (is_call)
);

// File: tb/cq1_decoder_test.sv
module cq1_decoder_test;

    logic        clk = 1'b0;
    logic [15:0] insn = 16'h0000;
    logic        rv64 = 1'b0;
    logic        valid;
    logic [3:0]  op;
    logic [4:0]  rd;
    logic [63:0] imm;
    logic        illegal;
    logic [1:0]  reason;
    logic        is_call;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    cq1_decoder uut (
        .insn    (insn),
        .rv64    (rv64),
        .valid   (valid),
        .op      (op),
        .rd      (rd),
        .imm     (imm),
        .illegal (illegal),
        .reason  (reason),
        .is_call (is_call)
    );

    typedef struct packed {
        logic        v;
        logic [3:0]  op;
        logic [4:0]  rd;
        logic [63:0] imm;
        logic        ill;
        logic [1:0]  rsn;
        logic        call;
    } res_t;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic longint bitv(input logic b, input int pos);
        return b ? (longint'(1) <<< pos) : 64'sd0;
    endfunction

    function automatic res_t ref_model(input logic [15:0] w, input logic m);
        res_t r;
        longint s6;
        longint val;
        r = '0;
        r.v = (w[1:0] == 2'b01);
        s6 = (w[12] ? -64'sd32 : 64'sd0) + longint'(w[6:2]);
        if (!r.v) begin
            r.op = 4'd15;
            return r;
        end
        r.rd = w[11:7];
        case (w[15:13])
            3'd0: begin
                r.op = 4'd0; val = s6;
                if ((w[11:7] == 0) && (s6 != 0)) r.rsn = 2'd1;
                if ((w[11:7] != 0) && (s6 == 0)) r.rsn = 2'd2;
            end
            3'd1: begin
                if (m) begin
                    r.op = 4'd1; val = s6;
                    if (w[11:7] == 0) r.rsn = 2'd1;
                end else begin
                    r.op = 4'd2; r.rd = 5'd1; r.call = 1'b1;
                    val = (w[12] ? -64'sd2048 : 64'sd0) + bitv(w[8], 10) + bitv(w[10], 9)
                        + bitv(w[9], 8) + bitv(w[6], 7) + bitv(w[7], 6) + bitv(w[2], 5)
                        + bitv(w[11], 4) + bitv(w[5], 3) + bitv(w[4], 2) + bitv(w[3], 1);
                end
            end
            3'd2: begin
                r.op = 4'd3; val = s6;
                if (w[11:7] == 0) r.rsn = 2'd1;
            end
            3'd3: begin
                if (w[11:7] == 5'd2) begin
                    r.op = 4'd4;
                    val = (w[12] ? -64'sd512 : 64'sd0) + bitv(w[4], 8) + bitv(w[3], 7)
                        + bitv(w[5], 6) + bitv(w[2], 5) + bitv(w[6], 4);
                    if (val == 0) r.rsn = 2'd2;
                end else begin
                    r.op = 4'd5; val = s6 * 4096;
                    if (w[11:7] == 0) r.rsn = 2'd1;
                    else if (val == 0) r.rsn = 2'd2;
                end
            end
            3'd4: begin
                r.op = 4'd6; val = s6; r.rd = 5'd8 + 5'(w[9:7]);
            end
            3'd5: begin
                r.op = 4'd7; r.rd = 5'd0;
                val = (w[12] ? -64'sd2048 : 64'sd0) + bitv(w[8], 10) + bitv(w[10], 9)
                    + bitv(w[9], 8) + bitv(w[6], 7) + bitv(w[7], 6) + bitv(w[2], 5)
                    + bitv(w[11], 4) + bitv(w[5], 3) + bitv(w[4], 2) + bitv(w[3], 1);
            end
            default: begin
                r.op = w[13] ? 4'd9 : 4'd8; r.rd = 5'd8 + 5'(w[9:7]);
                val = (w[12] ? -64'sd256 : 64'sd0) + bitv(w[6], 7) + bitv(w[5], 6)
                    + bitv(w[2], 5) + bitv(w[11], 4) + bitv(w[10], 3)
                    + bitv(w[4], 2) + bitv(w[3], 1);
            end
        endcase
        r.imm = 64'(val);
        r.ill = (r.rsn != 2'd0);
        return r;
    endfunction

    task automatic apply(input logic [15:0] w, input logic m);
        @(posedge clk);
        insn = w;
        rv64 = m;
        #2;
    endtask

    function automatic res_t observed();
        res_t r;
        r.v = valid; r.op = op; r.rd = rd; r.imm = imm;
        r.ill = illegal; r.rsn = reason; r.call = is_call;
        return r;
    endfunction

    task automatic compare(input string tag, input res_t act, input res_t exp);
        res_t a;
        res_t e;
        a = act;
        e = exp;
        if (!e.v) begin
            a.rd = '0; a.imm = '0;
            e.rd = '0; e.imm = '0;
        end
        checks = checks + 1;
        if (a !== e) begin
            fails = fails + 1;
            $display("FAIL %s insn=%h rv64=%0d actual v=%0d op=%0d rd=%0d imm=%h ill=%0d rsn=%0d call=%0d expected v=%0d op=%0d rd=%0d imm=%h ill=%0d rsn=%0d call=%0d",
                     tag, insn, rv64, a.v, a.op, a.rd, a.imm, a.ill, a.rsn, a.call,
                     e.v, e.op, e.rd, e.imm, e.ill, e.rsn, e.call);
        end
    endtask

    task automatic directed(input string tag, input logic [15:0] w, input logic m,
                            input logic [3:0] eop, input logic [4:0] erd,
                            input logic [63:0] eimm, input logic [1:0] ersn,
                            input logic ecall);
        res_t e;
        apply(w, m);
        e.v = 1'b1; e.op = eop; e.rd = erd; e.imm = eimm;
        e.rsn = ersn; e.ill = (ersn != 2'd0); e.call = ecall;
        compare(tag, observed(), e);
    endtask

    task automatic t_idle_state();
        res_t e;
        #2;
        e = '0; e.op = 4'd15;
        compare("R1 initial word", observed(), e);
        apply(16'h0002, 1'b0);
        compare("R1 quadrant two", observed(), e);
        apply(16'hFFFF, 1'b1);
        compare("R1 quadrant three", observed(), e);
    endtask

    task automatic t_small_forms();
        directed("R2/R9 addi x5 -1", 16'h12FD, 1'b0, 4'd0, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0);
        directed("R3 addi x0 nonzero", 16'h000D, 1'b0, 4'd0, 5'd0, 64'd3, 2'd1, 1'b0);
        directed("R3 addi zero imm", 16'h0181, 1'b0, 4'd0, 5'd3, 64'd0, 2'd2, 1'b0);
        directed("R3 nop legal", 16'h0001, 1'b0, 4'd0, 5'd0, 64'd0, 2'd0, 1'b0);
        directed("R4 addiw x0 rv64", 16'h3001, 1'b1, 4'd1, 5'd0, 64'hFFFF_FFFF_FFFF_FFE0, 2'd1, 1'b0);
        directed("R4 li x0", 16'h4005, 1'b0, 4'd3, 5'd0, 64'd1, 2'd1, 1'b0);
    endtask

    task automatic t_upper_forms();
        directed("R5 stack adjust -512", 16'h7101, 1'b0, 4'd4, 5'd2, 64'hFFFF_FFFF_FFFF_FE00, 2'd0, 1'b0);
        directed("R5 stack adjust zero", 16'h6101, 1'b0, 4'd4, 5'd2, 64'd0, 2'd2, 1'b0);
        directed("R6 lui x1 one", 16'h6085, 1'b0, 4'd5, 5'd1, 64'h1000, 2'd0, 1'b0);
        directed("R6 lui x0", 16'h6005, 1'b0, 4'd5, 5'd0, 64'h1000, 2'd1, 1'b0);
        directed("R6 lui zero imm", 16'h6181, 1'b0, 4'd5, 5'd3, 64'd0, 2'd2, 1'b0);
    endtask

    task automatic t_control_forms();
        directed("R7 jal rv32 sign", 16'h3001, 1'b0, 4'd2, 5'd1, 64'hFFFF_FFFF_FFFF_F800, 2'd0, 1'b1);
        directed("R7 j bit4", 16'hA801, 1'b0, 4'd7, 5'd0, 64'd16, 2'd0, 1'b0);
        directed("R8 beqz -256 x9", 16'hD081, 1'b0, 4'd8, 5'd9, 64'hFFFF_FFFF_FFFF_FF00, 2'd0, 1'b0);
        directed("R8 bnez 32 x8", 16'hE005, 1'b0, 4'd9, 5'd8, 64'd32, 2'd0, 1'b0);
    endtask

    task automatic t_sweep();
        for (int md = 0; md < 2; md++) begin
            for (int i = 0; i < 16384; i++) begin
                logic [15:0] w;
                w = {i[13:0], 2'b01};
                apply(w, md[0]);
                compare("R2/R3/R4/R5/R6/R7/R8/R9 sweep", observed(), ref_model(w, md[0]));
            end
        end
    endtask

    initial begin
        t_idle_state();
        t_small_forms();
        t_upper_forms();
        t_control_forms();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule